// File: doc/BRIEF.md
# Dual-Mode Processor Counter-Timer

This block is one processor's private counter-timer, reached through a small word-addressed register port and raising a single interrupt line. In counter mode it steps an internal period counter on each tick pulse. It shows that counter in units of 512, wraps it when it reaches a programmable limit, latches a reached flag and asserts its interrupt. Software acknowledges the event by reading the limit register.

An external controller can switch the block into user-timer mode through a mode input. In that mode the same two registers become the high and low words of a 64-bit free-running count. Software starts and stops it through a status bit, and the interrupt stays quiet. When the controller drops the mode input, the block returns to a free-running counter that continues from the low bits of the user count.

Top module: `ctm_timer`

## Requirements
- R1: After reset the interrupt is low, reads of register 0 and register 1 return 0, and a read of register 3 returns 1 (running, counter mode).
- R2: In counter mode each tick adds 512 to the value read from register 1; bits 30:9 hold the count, bit 31 holds the reached flag and bits 8:0 read as zero.
- R3: In counter mode, writing register 0 keeps only bits 30:9 as the limit L. On the L-th tick after a restart the count returns to 0, the reached flag is set and irq is raised.
- R4: A limit of zero makes the counter free-run: it wraps only when the count would reach 0x7FFFFE00, setting reached and raising irq.
- R5: In counter mode a read of register 0 returns the limit, clears the reached flag and lowers irq.
- R6: In counter mode a write to register 0 lowers irq and restarts the count from zero. A write to register 2 loads the limit and leaves the count running from its current value; register 2 reads back the limit.
- R7: In counter mode, writes to register 1 and register 3 change nothing observable.
- R8: In user mode irq never rises. A tick that takes the 64-bit count past its maximum sets the reached flag, shown in bit 31 of register 0, and wraps the count to zero.
- R9: In user mode register 0 carries count bits 62:32 in bits 30:0, and register 1 carries count bits 31:9 in bits 31:9. A write to either loads that half and clears reached, and counting carries from the low half into the high half.
- R10: In user mode, bit 0 written to register 3 starts (1) or stops (0) counting, and ticks are ignored while stopped. A write equal to the current state has no effect, and register 3 reads back the running flag.
- R11: Entering user mode clears the count, stops it and lowers irq. Leaving it restarts counting with a zero (free-run) limit and a count equal to bits 30:9 of the low word.
- R12: When a wrap and a register-0 read fall in the same cycle in counter mode, the wrap wins: reached and irq are both set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable that advances the period counter |
| user_mode | input | 1 | 1 selects user-timer mode, driven by an external controller |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects apply at the clock edge) |
| addr | input | 2 | Register word index 0..3 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high, zero otherwise |
| irq | output | 1 | Interrupt, counter mode only |

## Verification
The bench sets a limit with stray bits outside the count field, so a design that kept those bits would wrap late. It uses the no-restart limit register to show that only register 0 resets the count. It runs the free-run wrap at its top value by carrying a loaded user count across the mode change, which catches a design that wraps early or zeroes the count on the way out. It loads an all-ones 64-bit count and a carry-prone low word, which exposes a dropped carry or a spurious interrupt. It also lines up a wrap with an acknowledge read, where a design that gave the clear priority would lose the event.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    parameter int WORD_W = 32;
    parameter int SHIFT  = 9;
    localparam int CNT_PW = WORD_W - 1 - SHIFT;
    localparam int LO_PW  = WORD_W - SHIFT;
    localparam int HI_PW  = WORD_W - 1;
    localparam int USR_PW = LO_PW + HI_PW;

    typedef enum logic [1:0] {
        REG_LIMIT      = 2'd0,
        REG_COUNT      = 2'd1,
        REG_LIMIT_KEEP = 2'd2,
        REG_STATUS     = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic load_limit;
        logic restart;
        logic clr_flag;
        logic load_lo;
        logic load_hi;
        logic set_run;
        logic clr_run;
    } ctm_cmd_t;

    function automatic logic [CNT_PW-1:0] eff_limit(input logic [CNT_PW-1:0] lim);
        return (lim == '0) ? '1 : lim;
    endfunction

    function automatic logic [WORD_W-1:0] to_units(input logic [CNT_PW-1:0] p);
        return {1'b0, p, {SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/ctm_decode.sv
module ctm_decode
    import ctm_pkg::*;
(
    input  logic     wr_en,
    input  logic     rd_en,
    input  reg_sel_e sel,
    input  logic     user_mode,
    input  logic     running,
    input  logic     wbit0,
    output ctm_cmd_t cmd
);

    always_comb begin
        cmd = '0;
        if (!user_mode) begin
            if (wr_en && sel == REG_LIMIT) begin
                cmd.load_limit = 1'b1;
                cmd.restart    = 1'b1;
            end
            if (wr_en && sel == REG_LIMIT_KEEP) cmd.load_limit = 1'b1;
            if (rd_en && sel == REG_LIMIT) cmd.clr_flag = 1'b1;
        end else if (wr_en) begin
            case (sel)
                REG_LIMIT: cmd.load_hi = 1'b1;
                REG_COUNT: cmd.load_lo = 1'b1;
                REG_STATUS: begin
                    cmd.set_run = wbit0 && !running;
                    cmd.clr_run = !wbit0 && running;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ctm_core.sv
module ctm_core
    import ctm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              user_mode,
    input  logic              mode_rise,
    input  logic              mode_fall,
    input  ctm_cmd_t          cmd,
    input  logic [WORD_W-1:0] wdata,
    output logic [USR_PW-1:0] periods,
    output logic [CNT_PW-1:0] limit,
    output logic              running,
    output logic              wrap
);

    logic [USR_PW-1:0] p_nx;
    logic [CNT_PW-1:0] l_nx;
    logic              r_nx;
    logic [CNT_PW-1:0] cnt_lo;
    logic [CNT_PW:0]   cnt_inc;
    logic              ctr_hit;
    logic              usr_hit;

    assign cnt_lo  = periods[CNT_PW-1:0];
    assign cnt_inc = {1'b0, cnt_lo} + {{CNT_PW{1'b0}}, 1'b1};
    assign ctr_hit = cnt_inc >= {1'b0, eff_limit(limit)};
    assign usr_hit = &periods;

    always_comb begin
        p_nx = periods;
        l_nx = limit;
        r_nx = running;
        wrap = 1'b0;
        if (mode_rise) begin
            p_nx = '0;
            r_nx = 1'b0;
        end else if (mode_fall) begin
            p_nx = USR_PW'(cnt_lo);
            l_nx = '0;
            r_nx = 1'b1;
        end else if (!user_mode) begin
            if (cmd.load_limit) l_nx = wdata[WORD_W-2:SHIFT];
            if (cmd.restart) begin
                p_nx = '0;
            end else if (tick && running) begin
                if (ctr_hit) begin
                    p_nx = '0;
                    wrap = 1'b1;
                end else begin
                    p_nx = USR_PW'(cnt_inc[CNT_PW-1:0]);
                end
            end
        end else begin
            if (cmd.load_lo || cmd.load_hi) begin
                if (cmd.load_lo) p_nx[LO_PW-1:0] = wdata[WORD_W-1:SHIFT];
                if (cmd.load_hi) p_nx[USR_PW-1:LO_PW] = wdata[HI_PW-1:0];
            end else if (tick && running) begin
                p_nx = periods + USR_PW'(1);
                wrap = usr_hit;
            end
            if (cmd.set_run) r_nx = 1'b1;
            if (cmd.clr_run) r_nx = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            periods <= '0;
            limit   <= '0;
            running <= 1'b1;
        end else begin
            periods <= p_nx;
            limit   <= l_nx;
            running <= r_nx;
        end
    end

    // R6: a restarting limit write leaves the count at zero
    assert_restart_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (!user_mode && !mode_fall && cmd.restart) |=> (periods == '0));

    // R11: entering user mode clears and stops the count
    assert_enter_user_R11: assert property (@(posedge clk) disable iff (rst)
        mode_rise |=> (periods == '0 && !running));

endmodule

// File: rtl/ctm_flags.sv
module ctm_flags
    import ctm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wrap,
    input  logic     user_mode,
    input  logic     mode_rise,
    input  ctm_cmd_t cmd,
    output logic     reached,
    output logic     irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            reached <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (wrap) reached <= 1'b1;
            else if (cmd.clr_flag || cmd.load_lo || cmd.load_hi) reached <= 1'b0;

            if (wrap && !user_mode) irq <= 1'b1;
            else if (cmd.clr_flag || cmd.restart || mode_rise) irq <= 1'b0;
        end
    end

    // R8: no interrupt once user mode has been entered
    assert_user_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (user_mode && !mode_rise) |-> !irq);

    // R3: a counter-mode wrap leaves both flag and interrupt set
    assert_wrap_flags_R3: assert property (@(posedge clk) disable iff (rst)
        (wrap && !user_mode) |=> (irq && reached));

endmodule

// File: rtl/ctm_timer.sv
module ctm_timer
    import ctm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              user_mode,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              irq
);

    reg_sel_e          sel;
    ctm_cmd_t          cmd;
    logic              mode_q;
    logic              mode_rise;
    logic              mode_fall;
    logic [USR_PW-1:0] periods;
    logic [CNT_PW-1:0] limit;
    logic              running;
    logic              wrap;
    logic              reached;

    assign sel       = reg_sel_e'(addr);
    assign mode_rise = user_mode && !mode_q;
    assign mode_fall = !user_mode && mode_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= user_mode;
    end

    ctm_decode u_decode (
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .sel       (sel),
        .user_mode (user_mode),
        .running   (running),
        .wbit0     (wdata[0]),
        .cmd       (cmd)
    );

    ctm_core u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .user_mode (user_mode),
        .mode_rise (mode_rise),
        .mode_fall (mode_fall),
        .cmd       (cmd),
        .wdata     (wdata),
        .periods   (periods),
        .limit     (limit),
        .running   (running),
        .wrap      (wrap)
    );

    ctm_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .wrap      (wrap),
        .user_mode (user_mode),
        .mode_rise (mode_rise),
        .cmd       (cmd),
        .reached   (reached),
        .irq       (irq)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (!user_mode) begin
                case (sel)
                    REG_LIMIT, REG_LIMIT_KEEP: rdata = to_units(limit);
                    REG_COUNT: rdata = to_units(periods[CNT_PW-1:0]) | {reached, {(WORD_W-1){1'b0}}};
                    default:   rdata = WORD_W'(running);
                endcase
            end else begin
                case (sel)
                    REG_LIMIT:  rdata = {reached, periods[USR_PW-1:LO_PW]};
                    REG_COUNT:  rdata = {periods[LO_PW-1:0], {SHIFT{1'b0}}};
                    REG_STATUS: rdata = WORD_W'(running);
                    default:    rdata = '0;
                endcase
            end
        end
    end

    // R5: an acknowledge read with no competing wrap clears flag and interrupt
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == REG_LIMIT && !user_mode && !wrap) |=> (!irq && !reached));

    // R10: a status write matching the running state leaves it unchanged
    assert_run_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (user_mode && mode_q && wr_en && sel == REG_STATUS && (wdata[0] == running))
        |=> $stable(running));

    // R12: wrap wins over a same-cycle acknowledge
    assert_wrap_priority_R12: assert property (@(posedge clk) disable iff (rst)
        (wrap && !user_mode && cmd.clr_flag) |=> irq);

endmodule

// File: tb/tb_ctm_timer.sv
`timescale 1ns/1ps
module tb_ctm_timer;

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_MD = 2'd3;
    localparam logic [2:0] K_WR = 3'd0, K_RD = 3'd1, K_TK = 3'd2, K_MD = 3'd3, K_IRQ = 3'd4;

    typedef struct packed {
        logic [2:0]  kind;
        logic [1:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 73;
    localparam vec_t TBL [NV] = '{
        '{K_RD, 2'd3, 32'h0, 32'h1, 4'd1},            // R1 status
        '{K_RD, 2'd0, 32'h0, 32'h0, 4'd1},            // R1 limit
        '{K_RD, 2'd1, 32'h0, 32'h0, 4'd1},            // R1 count
        '{K_IRQ, 2'd0, 32'h0, 32'h0, 4'd1},           // R1 irq
        '{K_TK, 2'd0, 32'd3, 32'h0, 4'd2},
        '{K_RD, 2'd1, 32'h0, 32'h600, 4'd2},          // R2 3*512
        '{K_WR, 2'd0, 32'h8000_0A01, 32'h0, 4'd3},
        '{K_RD, 2'd0, 32'h0, 32'hA00, 4'd3},          // R3 masked limit
        '{K_RD, 2'd1, 32'h0, 32'h0, 4'd6},            // R6 restart
        '{K_TK, 2'd0, 32'd4, 32'h0, 4'd3},
        '{K_RD, 2'd1, 32'h0, 32'h800, 4'd3},          // R3 before limit
        '{K_IRQ, 2'd0, 32'h0, 32'h0, 4'd3},
        '{K_TK, 2'd0, 32'd1, 32'h0, 4'd3},
        '{K_RD, 2'd1, 32'h0, 32'h8000_0000, 4'd3},    // R3 wrapped, reached
        '{K_IRQ, 2'd0, 32'h0, 32'h1, 4'd3},
        '{K_RD, 2'd0, 32'h0, 32'hA00, 4'd5},          // R5 ack read
        '{K_IRQ, 2'd0, 32'h0, 32'h0, 4'd5},
        '{K_RD, 2'd1, 32'h0, 32'h0, 4'd5},
        '{K_TK, 2'd0, 32'd2, 32'h0, 4'd6},
        '{K_WR, 2'd2, 32'h1000, 32'h0, 4'd6},
        '{K_RD, 2'd1, 32'h0, 32'h400, 4'd6},          // R6 no restart
        '{K_RD, 2'd2, 32'h0, 32'h1000, 4'd6},
        '{K_WR, 2'd1, 32'h1234_5600, 32'h0, 4'd7},
        '{K_WR, 2'd3, 32'h0, 32'h0, 4'd7},
        '{K_RD, 2'd3, 32'h0, 32'h1, 4'd7},            // R7 status unchanged
        '{K_RD, 2'd1, 32'h0, 32'h400, 4'd7},          // R7 count unchanged
        '{K_TK, 2'd0, 32'd6, 32'h0, 4'd3},
        '{K_IRQ, 2'd0, 32'h0, 32'h1, 4'd3},
        '{K_WR, 2'd0, 32'h1000, 32'h0, 4'd6},
        '{K_IRQ, 2'd0, 32'h0, 32'h0, 4'd6},           // R6 irq dropped
        '{K_MD, 2'd0, 32'h1, 32'h0, 4'd11},
        '{K_RD, 2'd3, 32'h0, 32'h0, 4'd11},           // R11 stopped
        '{K_IRQ, 2'd0, 32'h0, 32'h0, 4'd11},
        '{K_RD, 2'd1, 32'h0, 32'h0, 4'd11},
        '{K_TK, 2'd0, 32'd5, 32'h0, 4'd10},
        '{K_RD, 2'd1, 32'h0, 32'h0, 4'd10},           // R10 stopped ignores ticks
        '{K_WR, 2'd3, 32'h1, 32'h0, 4'd10},
        '{K_RD, 2'd3, 32'h0, 32'h1, 4'd10},
        '{K_TK, 2'd0, 32'd3, 32'h0, 4'd10},
        '{K_RD, 2'd1, 32'h0, 32'h600, 4'd10},
        '{K_WR, 2'd3, 32'h1, 32'h0, 4'd10},
        '{K_TK, 2'd0, 32'd1, 32'h0, 4'd10},
        '{K_RD, 2'd1, 32'h0, 32'h800, 4'd10},         // R10 matching write
        '{K_WR, 2'd3, 32'h0, 32'h0, 4'd10},
        '{K_TK, 2'd0, 32'd2, 32'h0, 4'd10},
        '{K_RD, 2'd1, 32'h0, 32'h800, 4'd10},         // R10 stop
        '{K_RD, 2'd3, 32'h0, 32'h0, 4'd10},
        '{K_WR, 2'd1, 32'hFFFF_FE00, 32'h0, 4'd9},
        '{K_WR, 2'd0, 32'h5, 32'h0, 4'd9},
        '{K_WR, 2'd3, 32'h1, 32'h0, 4'd9},
        '{K_TK, 2'd0, 32'd1, 32'h0, 4'd9},
        '{K_RD, 2'd1, 32'h0, 32'h0, 4'd9},            // R9 low carried out
        '{K_RD, 2'd0, 32'h0, 32'h6, 4'd9},            // R9 high incremented
        '{K_WR, 2'd0, 32'h7FFF_FFFF, 32'h0, 4'd8},
        '{K_WR, 2'd1, 32'hFFFF_FE00, 32'h0, 4'd8},
        '{K_TK, 2'd0, 32'd1, 32'h0, 4'd8},
        '{K_RD, 2'd0, 32'h0, 32'h8000_0000, 4'd8},    // R8 64-bit wrap
        '{K_RD, 2'd1, 32'h0, 32'h0, 4'd8},
        '{K_IRQ, 2'd0, 32'h0, 32'h0, 4'd8},
        '{K_WR, 2'd1, 32'h200, 32'h0, 4'd9},
        '{K_RD, 2'd0, 32'h0, 32'h0, 4'd9},            // R9 reached cleared
        '{K_RD, 2'd1, 32'h0, 32'h200, 4'd9},
        '{K_WR, 2'd1, 32'h7FFF_F800, 32'h0, 4'd11},
        '{K_MD, 2'd0, 32'h0, 32'h0, 4'd11},
        '{K_RD, 2'd3, 32'h0, 32'h1, 4'd11},           // R11 running again
        '{K_RD, 2'd0, 32'h0, 32'h0, 4'd11},           // R11 free-run limit
        '{K_RD, 2'd1, 32'h0, 32'h7FFF_F800, 4'd11},   // R11 count kept
        '{K_TK, 2'd0, 32'd2, 32'h0, 4'd4},
        '{K_RD, 2'd1, 32'h0, 32'h7FFF_FC00, 4'd4},    // R4 top of range
        '{K_IRQ, 2'd0, 32'h0, 32'h0, 4'd4},
        '{K_TK, 2'd0, 32'd1, 32'h0, 4'd4},
        '{K_RD, 2'd1, 32'h0, 32'h8000_0000, 4'd4},    // R4 free-run wrap
        '{K_IRQ, 2'd0, 32'h0, 32'h1, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        user_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [31:0] rd_val;

    always #2.5 clk = ~clk;

    ctm_timer dut (
        .clk(clk), .rst(rst), .tick(tick), .user_mode(user_mode),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic t,
                       input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; tick = t; addr = a; wdata = d;
        #1 rd_val = rdata;
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0; tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            case (TBL[i].kind)
                K_WR: cyc(1'b1, 1'b0, 1'b0, TBL[i].addr, TBL[i].data);
                K_RD: begin
                    cyc(1'b0, 1'b1, 1'b0, TBL[i].addr, 32'h0);
                    check(int'(TBL[i].req), rd_val, TBL[i].exp);
                end
                K_TK: for (int k = 0; k < int'(TBL[i].data); k++)
                          cyc(1'b0, 1'b0, 1'b1, 2'd0, 32'h0);
                K_MD: begin
                    @(negedge clk);
                    user_mode = TBL[i].data[0];
                    @(posedge clk);
                    #1;
                end
                default: begin
                    @(negedge clk);
                    #1 check(int'(TBL[i].req), {31'h0, irq}, TBL[i].exp);
                end
            endcase
        end

        // R12: wrap and acknowledge read in the same cycle
        cyc(1'b1, 1'b0, 1'b0, 2'd0, 32'h400);
        cyc(1'b0, 1'b0, 1'b1, 2'd0, 32'h0);
        cyc(1'b0, 1'b1, 1'b1, 2'd0, 32'h0);
        check(12, rd_val, 32'h400);
        @(negedge clk);
        #1 check(12, {31'h0, irq}, 32'h1);
        cyc(1'b0, 1'b1, 1'b0, 2'd1, 32'h0);
        check(12, rd_val, 32'h8000_0000);

        // R1: reset in the middle of activity
        cyc(1'b0, 1'b0, 1'b1, 2'd0, 32'h0);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        #1 check(1, {31'h0, irq}, 32'h0);
        cyc(1'b0, 1'b1, 1'b0, 2'd3, 32'h0);
        check(1, rd_val, 32'h1);
        cyc(1'b0, 1'b1, 1'b0, 2'd0, 32'h0);
        check(1, rd_val, 32'h0);
        cyc(1'b0, 1'b1, 1'b0, 2'd1, 32'h0);
        check(1, rd_val, 32'h0);

        finish_run();
    end

endmodule